// File: doc/BRIEF.md
# Virtual Link Transmit Scheduler

This block decides which frame an end system puts on its physical link next. It deals in frame descriptors only: a descriptor names a virtual link, a sub-queue inside that link, and a frame length in bytes. Descriptors are written in through a valid/ready port. Each virtual link has a length ceiling, and a descriptor above that ceiling is dropped when it is accepted. Each link also has a minimum spacing between its frames, set as a power-of-two number of millisecond ticks. A per-link down-counter enforces that spacing.

The scheduler serves the eligible links in round-robin order, and serves the sub-queues of the chosen link in round-robin order. A per-link sequence number is stamped on a frame only at the moment the frame is selected. Each selected frame is offered twice on the output handshake: once tagged for network A and once tagged for network B. After the B copy is taken, the physical link is held busy for the frame length plus an interframe gap, counted in byte times, with one clock equal to one byte time. Only then can the next selection happen.

Top module: `vl_tx_sched`

## Requirements
- R1: After reset, `out_valid` is low, `viol_count` is zero and `enq_ready` is high.
- R2: Link v's spacing exponent k is `cfg_bag_exp[3v+2:3v]`. When a frame of link v is selected, that link's counter reloads to 2^k. A tick arriving on the selection edge does not count. The next frame of link v is selected on the edge after the 2^k-th later tick, provided the output link is free.
- R3: Link v's length ceiling is `cfg_lmax[11v+10:11v]`. An accepted descriptor whose length is above the ceiling is discarded, is never emitted, and adds one to `viol_count`. A length equal to the ceiling is kept.
- R4: Each link's sequence numbers start at 0 after reset, count up by one per selected frame, and go from 255 to 1.
- R5: A sequence number is given out when the frame is selected, not when it is enqueued, so numbers follow the order of emission.
- R6: Within a link, non-empty sub-queues are served round-robin. The search starts at the sub-queue after the one served last, and sub-queue 0 is first after reset.
- R7: Among eligible links (counter at zero and at least one non-empty sub-queue), the search starts at the link after the one granted last, with link 0 first after reset.
- R8: Every selected frame is offered first with `out_net` = 0 (network A). Once that copy is accepted, the same link, sub-queue, sequence number and length are offered with `out_net` = 1 (network B).
- R9: While `out_valid` is high and `out_ready` is low, every output holds its value.
- R10: If a frame is eligible, `out_valid` rises exactly length + 12 clocks after the edge on which the B copy of the previous frame was accepted, and never earlier.
- R11: Each sub-queue holds 4 descriptors. `enq_ready` is low for a full sub-queue, and a descriptor presented then is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one byte time per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| cfg_bag_exp | input | 3*NUM_VL | Per-link spacing exponent, 2^k ticks |
| cfg_lmax | input | LEN_W*NUM_VL | Per-link length ceiling in bytes |
| enq_valid | input | 1 | Descriptor present |
| enq_ready | output | 1 | Addressed sub-queue has room |
| enq_vl | input | clog2(NUM_VL) | Descriptor link index |
| enq_sq | input | clog2(NUM_SQ) | Descriptor sub-queue index |
| enq_len | input | LEN_W | Descriptor frame length in bytes |
| viol_count | output | 16 | Count of length-ceiling discards |
| out_valid | output | 1 | Output copy offered |
| out_ready | input | 1 | Output copy accepted |
| out_vl | output | clog2(NUM_VL) | Link of the offered frame |
| out_sq | output | clog2(NUM_SQ) | Sub-queue of the offered frame |
| out_seq | output | SEQ_W | Sequence number stamped at selection |
| out_len | output | LEN_W | Frame length in bytes |
| out_net | output | 1 | 0 for network A copy, 1 for network B copy |

## Verification
The bench builds the block with its defaults: eight links, four sub-queues of four entries each, 11-bit lengths and 8-bit sequence numbers. A depth of four means a full sub-queue takes only four pushes. An 8-bit counter means the 255-to-1 wrap takes only 257 frames on one link. The millisecond tick is shortened to one pulse every ten clocks, so a 2^3 spacing spans 80 clocks and dominates the wire gap. That makes the exact tick count between frames measurable. While a blocker frame is held under backpressure, descriptors are preloaded so that every later selection meets a known round-robin state.

// File: rtl/vl_tx_sched.sv
module vl_tx_sched #(
  parameter int NUM_VL = 8,
  parameter int NUM_SQ = 4,
  parameter int DEPTH  = 4,
  parameter int LEN_W  = 11,
  parameter int SEQ_W  = 8,
  parameter int IFG    = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ms_tick,
  input  logic [NUM_VL*3-1:0]       cfg_bag_exp,
  input  logic [NUM_VL*LEN_W-1:0]   cfg_lmax,
  input  logic                      enq_valid,
  output logic                      enq_ready,
  input  logic [$clog2(NUM_VL)-1:0] enq_vl,
  input  logic [$clog2(NUM_SQ)-1:0] enq_sq,
  input  logic [LEN_W-1:0]          enq_len,
  output logic [15:0]               viol_count,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [$clog2(NUM_VL)-1:0] out_vl,
  output logic [$clog2(NUM_SQ)-1:0] out_sq,
  output logic [SEQ_W-1:0]          out_seq,
  output logic [LEN_W-1:0]          out_len,
  output logic                      out_net
);
  localparam int VL_W  = $clog2(NUM_VL);
  localparam int SQ_W  = $clog2(NUM_SQ);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int GAP_W = LEN_W + 1;
  localparam int BAG_W = 8;

  logic [LEN_W-1:0] mem    [NUM_VL][NUM_SQ][DEPTH];
  logic [PTR_W-1:0] rd_ptr [NUM_VL][NUM_SQ];
  logic [PTR_W-1:0] wr_ptr [NUM_VL][NUM_SQ];
  logic [CNT_W-1:0] cnt    [NUM_VL][NUM_SQ];
  logic             push_hit [NUM_VL][NUM_SQ];
  logic             pop_hit  [NUM_VL][NUM_SQ];
  logic [BAG_W-1:0] bag_cnt [NUM_VL];
  logic [SEQ_W-1:0] seq_nx  [NUM_VL];
  logic [SQ_W-1:0]  sq_ptr  [NUM_VL];
  logic [NUM_VL-1:0] elig;
  logic [VL_W-1:0]  rr_vl, gvl;
  logic [SQ_W-1:0]  gsq;
  logic             found, sq_found;
  logic [GAP_W-1:0] gap_cnt;
  logic             too_long, push, sel, b_done;

  assign enq_ready = cnt[enq_vl][enq_sq] != CNT_W'(DEPTH);
  assign too_long  = enq_len > cfg_lmax[enq_vl*LEN_W +: LEN_W];
  assign push      = enq_valid && enq_ready && !too_long;
  assign sel       = found && !out_valid && gap_cnt == '0;
  assign b_done    = out_valid && out_ready && out_net;

  always_comb begin
    for (int v = 0; v < NUM_VL; v++) begin
      elig[v] = 1'b0;
      for (int s = 0; s < NUM_SQ; s++)
        if (cnt[v][s] != '0) elig[v] = 1'b1;
      if (bag_cnt[v] != '0) elig[v] = 1'b0;
    end
  end

  always_comb begin
    found = 1'b0;
    gvl   = '0;
    for (int i = 0; i < NUM_VL; i++)
      if (!found && elig[rr_vl + VL_W'(i)]) begin
        found = 1'b1;
        gvl   = rr_vl + VL_W'(i);
      end
    sq_found = 1'b0;
    gsq      = '0;
    for (int j = 0; j < NUM_SQ; j++)
      if (!sq_found && cnt[gvl][sq_ptr[gvl] + SQ_W'(j)] != '0) begin
        sq_found = 1'b1;
        gsq      = sq_ptr[gvl] + SQ_W'(j);
      end
  end

  always_comb begin
    for (int v = 0; v < NUM_VL; v++)
      for (int s = 0; s < NUM_SQ; s++) begin
        push_hit[v][s] = push && enq_vl == VL_W'(v) && enq_sq == SQ_W'(s);
        pop_hit[v][s]  = sel && gvl == VL_W'(v) && gsq == SQ_W'(s);
      end
  end

  always_ff @(posedge clk)
    if (push) mem[enq_vl][enq_sq][wr_ptr[enq_vl][enq_sq]] <= enq_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_net    <= 1'b0;
      out_vl     <= '0;
      out_sq     <= '0;
      out_seq    <= '0;
      out_len    <= '0;
      rr_vl      <= '0;
      gap_cnt    <= '0;
      viol_count <= '0;
      for (int v = 0; v < NUM_VL; v++) begin
        bag_cnt[v] <= '0;
        seq_nx[v]  <= '0;
        sq_ptr[v]  <= '0;
        for (int s = 0; s < NUM_SQ; s++) begin
          rd_ptr[v][s] <= '0;
          wr_ptr[v][s] <= '0;
          cnt[v][s]    <= '0;
        end
      end
    end else begin
      if (enq_valid && enq_ready && too_long) viol_count <= viol_count + 16'd1;

      for (int v = 0; v < NUM_VL; v++) begin
        if (sel && gvl == VL_W'(v))
          bag_cnt[v] <= BAG_W'(1) << cfg_bag_exp[v*3 +: 3];
        else if (ms_tick && bag_cnt[v] != '0)
          bag_cnt[v] <= bag_cnt[v] - 1'b1;
        for (int s = 0; s < NUM_SQ; s++) begin
          if (push_hit[v][s]) wr_ptr[v][s] <= wr_ptr[v][s] + 1'b1;
          if (pop_hit[v][s])  rd_ptr[v][s] <= rd_ptr[v][s] + 1'b1;
          cnt[v][s] <= cnt[v][s] + CNT_W'(push_hit[v][s]) - CNT_W'(pop_hit[v][s]);
        end
      end

      if (sel) begin
        out_valid   <= 1'b1;
        out_net     <= 1'b0;
        out_vl      <= gvl;
        out_sq      <= gsq;
        out_len     <= mem[gvl][gsq][rd_ptr[gvl][gsq]];
        out_seq     <= seq_nx[gvl];
        seq_nx[gvl] <= (seq_nx[gvl] == {SEQ_W{1'b1}}) ? SEQ_W'(1) : seq_nx[gvl] + 1'b1;
        sq_ptr[gvl] <= gsq + 1'b1;
        rr_vl       <= gvl + 1'b1;
      end else if (out_valid && out_ready) begin
        if (!out_net) out_net   <= 1'b1;
        else          out_valid <= 1'b0;
      end

      if (b_done)              gap_cnt <= GAP_W'(out_len) + GAP_W'(IFG - 1);
      else if (gap_cnt != '0)  gap_cnt <= gap_cnt - 1'b1;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable({out_vl, out_sq, out_seq, out_len, out_net}));

  assert_copy_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_net |=> out_valid && out_net && $stable({out_vl, out_sq, out_seq, out_len}));

  assert_a_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !out_net);

  assert_wire_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    b_done |=> !out_valid);

  for (genvar v = 0; v < NUM_VL; v++) begin : g_chk_vl
    for (genvar s = 0; s < NUM_SQ; s++) begin : g_chk_sq
      assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt[v][s] <= CNT_W'(DEPTH));
    end
  end
endmodule

// File: tb/test_vl_tx_sched.sv
`timescale 1ns/1ps
module test_vl_tx_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ms_tick = 1'b0;
  logic [23:0] cfg_bag_exp;
  logic [87:0] cfg_lmax;
  logic        enq_valid = 1'b0;
  logic        enq_ready;
  logic [2:0]  enq_vl = '0;
  logic [1:0]  enq_sq = '0;
  logic [10:0] enq_len = '0;
  logic [15:0] viol_count;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [2:0]  out_vl;
  logic [1:0]  out_sq;
  logic [7:0]  out_seq;
  logic [10:0] out_len;
  logic        out_net;

  int nchk = 0, nfail = 0, cyc = 0, tick_seen = 0, scen = 0;
  bit gap_on = 1'b0;
  int exp_ticks [8];
  int mseq [8];
  logic [23:0] expq [$];

  vl_tx_sched i_vl_tx_sched (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .cfg_bag_exp(cfg_bag_exp), .cfg_lmax(cfg_lmax),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_vl(enq_vl),
    .enq_sq(enq_sq), .enq_len(enq_len), .viol_count(viol_count),
    .out_valid(out_valid), .out_ready(out_ready), .out_vl(out_vl),
    .out_sq(out_sq), .out_seq(out_seq), .out_len(out_len), .out_net(out_net));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ms_tick) tick_seen <= tick_seen + 1;
  end

  initial begin
    int tdiv = 0;
    forever begin
      @(negedge clk);
      ms_tick = (tdiv == 9);
      tdiv = (tdiv == 9) ? 0 : tdiv + 1;
    end
  end

  task automatic check(bit ok, string msg);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic expect_frame(int v, int s, int l);
    expq.push_back({3'(v), 2'(s), 8'(mseq[v]), 11'(l)});
    mseq[v] = (mseq[v] == 255) ? 1 : mseq[v] + 1;
  endtask

  task automatic push(int v, int s, int l);
    @(negedge clk);
    enq_vl = 3'(v); enq_sq = 2'(s); enq_len = 11'(l); enq_valid = 1'b1;
    #1;
    while (!enq_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (120) @(negedge clk);
  endtask

  // scoreboard monitor
  logic [24:0] pf;
  logic [23:0] a_copy, e;
  bit pv = 0, pstall = 0;
  int lb_cyc = 0, lb_scen = -1, gap_len = 0;
  int last_t [8];
  bit have_t [8];

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (pstall)
        check(out_valid && {out_vl, out_sq, out_seq, out_len, out_net} == pf,
              $sformatf("R9 hold under stall: got valid=%0b fields=%h exp fields=%h",
                        out_valid, {out_vl, out_sq, out_seq, out_len, out_net}, pf));
      if (out_valid && !pv) begin
        check(out_net == 1'b0, $sformatf("R8 first copy net: got %0d exp 0", out_net));
        if (gap_on && lb_scen == scen)
          check(cyc - lb_cyc == gap_len,
                $sformatf("R10 wire gap: got %0d exp %0d", cyc - lb_cyc, gap_len));
        if (exp_ticks[out_vl] != 0) begin
          if (have_t[out_vl])
            check(tick_seen - last_t[out_vl] == exp_ticks[out_vl],
                  $sformatf("R2 ticks between frames of link %0d: got %0d exp %0d",
                            out_vl, tick_seen - last_t[out_vl], exp_ticks[out_vl]));
          have_t[out_vl] = 1'b1;
          last_t[out_vl] = tick_seen;
        end
      end
      if (out_valid && out_ready) begin
        if (!out_net) begin
          if (expq.size() == 0)
            check(1'b0, $sformatf("R3/R11 unexpected frame: got vl=%0d sq=%0d len=%0d exp none",
                                  out_vl, out_sq, out_len));
          else begin
            e = expq.pop_front();
            check({out_vl, out_sq, out_seq, out_len} == e,
                  $sformatf("R4/R5/R6/R7 frame: got vl=%0d sq=%0d seq=%0d len=%0d exp vl=%0d sq=%0d seq=%0d len=%0d",
                            out_vl, out_sq, out_seq, out_len, e[23:21], e[20:19], e[18:11], e[10:0]));
          end
          a_copy = {out_vl, out_sq, out_seq, out_len};
        end else begin
          check({out_vl, out_sq, out_seq, out_len} == a_copy,
                $sformatf("R8 B copy: got %h exp %h", {out_vl, out_sq, out_seq, out_len}, a_copy));
          lb_cyc  = cyc + 1;
          lb_scen = scen;
          gap_len = int'(out_len) + 12;
        end
      end
      pv     = out_valid;
      pstall = out_valid && !out_ready;
      pf     = {out_vl, out_sq, out_seq, out_len, out_net};
    end
  end

  task automatic run_all();
    // R3: length ceiling on link 6 is 50
    scen = 1; out_ready = 1'b1; gap_on = 1'b0;
    push(6, 0, 51);
    repeat (20) @(negedge clk);
    check(viol_count == 16'd1, $sformatf("R3 discard count: got %0d exp 1", viol_count));
    check(!out_valid, $sformatf("R3 discarded not emitted: got valid=%0b exp 0", out_valid));
    expect_frame(6, 1, 50);
    push(6, 1, 50);
    drain();
    check(viol_count == 16'd1, $sformatf("R3 equal length kept: got count %0d exp 1", viol_count));

    // R5/R6: sub-queue round robin, numbering at selection
    scen = 2; out_ready = 1'b0; gap_on = 1'b1;
    expect_frame(7, 0, 60);
    push(7, 0, 60);
    push(0, 2, 20); push(0, 2, 21); push(0, 0, 22); push(0, 1, 23);
    expect_frame(0, 0, 22); expect_frame(0, 1, 23);
    expect_frame(0, 2, 20); expect_frame(0, 2, 21);
    repeat (5) @(negedge clk);
    out_ready = 1'b1;
    drain();

    // R7: link round robin
    scen = 3; out_ready = 1'b0;
    expect_frame(7, 0, 30);
    push(7, 0, 30);
    push(5, 0, 11); push(2, 0, 12); push(0, 0, 13); push(0, 0, 14);
    expect_frame(0, 0, 13); expect_frame(2, 0, 12);
    expect_frame(5, 0, 11); expect_frame(0, 0, 14);
    repeat (3) @(negedge clk);
    out_ready = 1'b1;
    drain();

    // R11 full sub-queue, R9 stall hold
    scen = 4; out_ready = 1'b0;
    expect_frame(7, 0, 40);
    push(7, 0, 40);
    for (int l = 5; l <= 8; l++) begin
      expect_frame(4, 3, l);
      push(4, 3, l);
    end
    @(negedge clk);
    enq_vl = 3'd4; enq_sq = 2'd3; enq_len = 11'd9; enq_valid = 1'b1;
    #1 check(!enq_ready, $sformatf("R11 full sub-queue ready: got %0b exp 0", enq_ready));
    @(negedge clk);
    enq_valid = 1'b0;
    repeat (10) @(negedge clk);
    out_ready = 1'b1;
    drain();
    check(enq_ready, $sformatf("R11 ready after drain: got %0b exp 1", enq_ready));

    // R2: link 3 has exponent 3
    scen = 5; gap_on = 1'b0;
    for (int n = 0; n < 3; n++) begin
      expect_frame(3, 0, 10);
      push(3, 0, 10);
    end
    drain();

    // R4: wrap 255 -> 1 on link 1
    scen = 6; gap_on = 1'b1;
    for (int n = 0; n < 257; n++) begin
      expect_frame(1, 0, 4);
      push(1, 0, 4);
    end
    drain();
    check(expq.size() == 0, $sformatf("R11 leftover expectations: got %0d exp 0", expq.size()));
  endtask

  initial begin
    for (int v = 0; v < 8; v++) begin
      cfg_bag_exp[v*3 +: 3] = (v == 3) ? 3'd3 : 3'd0;
      cfg_lmax[v*11 +: 11]  = (v == 6) ? 11'd50 : 11'd100;
      exp_ticks[v] = (v == 3) ? 8 : 0;
      mseq[v] = 0;
      have_t[v] = 1'b0;
      last_t[v] = 0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!out_valid, $sformatf("R1 reset valid: got %0b exp 0", out_valid));
    check(viol_count == 16'd0, $sformatf("R1 reset count: got %0d exp 0", viol_count));
    check(enq_ready, $sformatf("R1 reset ready: got %0b exp 1", enq_ready));
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R1-watchdog expired: got hung exp finished");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule